// File: doc/BRIEF.md
# Shared-Port Frame Memory Scheduler

This block sits in front of one true-dual-port frame memory and splits its two ports between two clients. Port A belongs to display scanout alone. A scanout read is accepted in every cycle, with no handshake. The word comes back exactly one cycle later, together with a valid strobe. Port B belongs to the rasterizer. A whole 32-bit pixel word goes straight into memory on the cycle the writer's handshake completes.

A 4-bit pixel update cannot be done with a single write. The sequencer first reads the word that holds the pixel. It waits for the data, replaces the chosen nibble, and writes the word back. While that runs, the writer's ready output is held low. Any write that arrives in that time, including one aimed at the same byte, waits until the write-back is done. No update is lost, and the memory is never copied to give scanout a port of its own.

Top module: `vram_arb_top`

## Requirements
- R1: A scanout request with `scan_addr` = A, taken at a clock edge, makes `scan_valid` high after the next edge and puts the word at A on `scan_data` for that one cycle.
- R2: `scan_valid` is low in every cycle that does not follow an accepted scanout request.
- R3: Scanout is never stalled. A request is served in every cycle, including cycles in which port B is busy writing or running a nibble update.
- R4: When `wr_nib` = 0, an accepted write stores all 32 bits of `wr_data` at word `wr_addr` on the accepting edge, and `wr_ready` stays high. Such writes can therefore follow one another on every cycle.
- R5: When `wr_nib` = 1, an accepted write replaces bits [4*S+3 : 4*S] of word `wr_addr` with `wr_data[3:0]`, where S = `wr_sub`. `wr_sub[2:1]` selects the byte and `wr_sub[0]` selects its high nibble (1) or low nibble (0). All other bits of the word keep their value.
- R6: After a nibble write is accepted, `wr_ready` is low for exactly two cycles. The merged word is written back on the second edge after the accepting edge, and `wr_ready` is high again after that edge.
- R7: A write presented while `wr_ready` is low is held and accepted once ready returns, in issue order. Two nibble writes to the same byte, issued back to back, both appear in the final word.
- R8: Memory reads return old data when a write lands in the same cycle. A scanout read of a word in the same cycle as a port B write to that word returns the old word. Scanout reads issued on the accepting edge, the read edge or the write-back edge of a nibble update also return the word as it was before the update.
- R9: While `rst` is high, the sequencer returns to idle: after a reset edge, `wr_ready` is high and `scan_valid` is low. The memory contents are not cleared.
- R10: After any mix of full writes and nibble writes, each word read by scanout equals the result of applying the accepted writes in acceptance order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| scan_req | input | 1 | Scanout read request, taken every cycle |
| scan_addr | input | ADDR_W | Scanout word address |
| scan_valid | output | 1 | Scanout read data valid |
| scan_data | output | 32 | Scanout read data |
| wr_valid | input | 1 | Rasterizer write valid |
| wr_ready | output | 1 | Rasterizer write ready, low during a nibble update |
| wr_nib | input | 1 | 1 = 4-bit pixel update, 0 = full 32-bit word write |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_sub | input | 3 | Nibble index inside the word (nibble writes only) |
| wr_data | input | 32 | Write data; nibble writes use bits [3:0] |

## Verification
The block is driven with several patterns:
- back-to-back full writes over every word, which separates a zero-stall write path from one that inserts bubbles;
- nibble writes sweeping all eight nibble indices of one word, which exposes wrong byte or high/low selection;
- a nibble write overlapped with scanout reads of the same word on each of its three edges, which tells a read-first memory from a write-first one and pins down the exact write-back edge;
- two held nibble writes into the same byte, which shows whether the stall loses or reorders an update.

A long random mix of full and nibble writes then ends with a read of the whole memory, compared against a model.

// File: rtl/vram_arb_pkg.sv
package vram_arb_pkg;

    // Word layout shared by the memory and the nibble merge logic
    localparam int WORD_W    = 32;
    localparam int NIB_W     = 4;
    localparam int NIBS      = WORD_W / NIB_W;
    localparam int NIB_SEL_W = $clog2(NIBS);

    // Port B sequencer phases
    typedef enum logic [1:0] {
        PB_IDLE  = 2'd0,
        PB_FETCH = 2'd1,
        PB_STORE = 2'd2
    } pb_phase_e;

    // Pending nibble update held across the fetch and store phases
    typedef struct packed {
        logic [NIB_SEL_W-1:0] sel;
        logic [NIB_W-1:0]     nib;
    } nib_op_t;

    // Replace one nibble of a word; sel[0] picks high/low nibble of byte sel[2:1]
    function automatic logic [WORD_W-1:0] put_nibble(
        input logic [WORD_W-1:0]    word,
        input logic [NIB_SEL_W-1:0] sel,
        input logic [NIB_W-1:0]     nib
    );
        logic [WORD_W-1:0] res;
        res = word;
        for (int i = 0; i < NIBS; i++) begin
            if (sel == NIB_SEL_W'(i)) begin
                res[i*NIB_W +: NIB_W] = nib;
            end
        end
        return res;
    endfunction

endpackage

// File: rtl/vram_tdp_mem.sv
module vram_tdp_mem #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              a_en,
    input  logic              a_we,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    input  logic              b_en,
    input  logic              b_we,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [0:DEPTH-1];

    // Both ports read old data on a same-cycle write (read-first)
    always_ff @(posedge clk) begin
        if (a_en) begin
            a_rdata <= mem[a_addr];
            if (a_we) begin
                mem[a_addr] <= a_wdata;
            end
        end
        if (b_en) begin
            b_rdata <= mem[b_addr];
            if (b_we) begin
                mem[b_addr] <= b_wdata;
            end
        end
    end

endmodule

// File: rtl/vram_scan_port.sv
module vram_scan_port (
    input  logic clk,
    input  logic rst,
    input  logic req,
    output logic mem_en,
    output logic valid
);
    // Port A only ever reads; every request is granted
    assign mem_en = req;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
        end else begin
            valid <= req;
        end
    end

endmodule

// File: rtl/vram_rmw_seq.sv
module vram_rmw_seq
    import vram_arb_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_valid,
    output logic                 wr_ready,
    input  logic                 wr_nib,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [NIB_SEL_W-1:0] wr_sub,
    input  logic [WORD_W-1:0]    wr_data,
    output logic                 b_en,
    output logic                 b_we,
    output logic [ADDR_W-1:0]    b_addr,
    output logic [WORD_W-1:0]    b_wdata,
    input  logic [WORD_W-1:0]    b_rdata
);
    pb_phase_e         phase_q, phase_d;
    logic [ADDR_W-1:0] addr_q;
    nib_op_t           op_q;
    logic              take;

    assign wr_ready = (phase_q == PB_IDLE);
    assign take     = wr_valid && wr_ready;

    always_comb begin
        phase_d = phase_q;
        b_en    = 1'b0;
        b_we    = 1'b0;
        b_addr  = addr_q;
        b_wdata = wr_data;
        unique case (phase_q)
            PB_IDLE: begin
                b_addr = wr_addr;
                if (take && !wr_nib) begin
                    b_en = 1'b1;
                    b_we = 1'b1;
                end
                if (take && wr_nib) begin
                    phase_d = PB_FETCH;
                end
            end
            PB_FETCH: begin
                b_en    = 1'b1;
                phase_d = PB_STORE;
            end
            PB_STORE: begin
                b_en    = 1'b1;
                b_we    = 1'b1;
                b_wdata = put_nibble(b_rdata, op_q.sel, op_q.nib);
                phase_d = PB_IDLE;
            end
            default: phase_d = PB_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PB_IDLE;
        end else begin
            phase_q <= phase_d;
        end
    end

    always_ff @(posedge clk) begin
        if (take && wr_nib) begin
            addr_q     <= wr_addr;
            op_q.sel   <= wr_sub;
            op_q.nib   <= wr_data[NIB_W-1:0];
        end
    end

endmodule

// File: rtl/vram_arb_top.sv
module vram_arb_top
    import vram_arb_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 scan_req,
    input  logic [ADDR_W-1:0]    scan_addr,
    output logic                 scan_valid,
    output logic [WORD_W-1:0]    scan_data,
    input  logic                 wr_valid,
    output logic                 wr_ready,
    input  logic                 wr_nib,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [NIB_SEL_W-1:0] wr_sub,
    input  logic [WORD_W-1:0]    wr_data
);
    logic              a_en;
    logic              b_en;
    logic              b_we;
    logic [ADDR_W-1:0] b_addr;
    logic [WORD_W-1:0] b_wdata;
    logic [WORD_W-1:0] b_rdata;

    vram_scan_port u_scan (
        .clk    (clk),
        .rst    (rst),
        .req    (scan_req),
        .mem_en (a_en),
        .valid  (scan_valid)
    );

    vram_rmw_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .wr_valid (wr_valid),
        .wr_ready (wr_ready),
        .wr_nib   (wr_nib),
        .wr_addr  (wr_addr),
        .wr_sub   (wr_sub),
        .wr_data  (wr_data),
        .b_en     (b_en),
        .b_we     (b_we),
        .b_addr   (b_addr),
        .b_wdata  (b_wdata),
        .b_rdata  (b_rdata)
    );

    vram_tdp_mem #(.ADDR_W(ADDR_W), .DATA_W(WORD_W)) u_mem (
        .clk     (clk),
        .a_en    (a_en),
        .a_we    (1'b0),
        .a_addr  (scan_addr),
        .a_wdata ('0),
        .a_rdata (scan_data),
        .b_en    (b_en),
        .b_we    (b_we),
        .b_addr  (b_addr),
        .b_wdata (b_wdata),
        .b_rdata (b_rdata)
    );

endmodule

// File: rtl/vram_arb_chk.sv
module vram_arb_chk (
    input logic clk,
    input logic rst,
    input logic scan_req,
    input logic scan_valid,
    input logic wr_valid,
    input logic wr_ready,
    input logic wr_nib
);
    // R1
    scan_latency_chk: assert property (@(posedge clk) disable iff (rst)
        scan_req |=> scan_valid);

    // R2
    scan_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !scan_req |=> !scan_valid);

    // R4
    full_nostall_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_ready && !wr_nib) |=> wr_ready);

    // R6
    rmw_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_ready && wr_nib) |=> !wr_ready);

    // R6
    rmw_second_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(wr_ready) |=> !wr_ready);

    // R6
    rmw_release_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_ready && !$past(wr_ready) && !$past(rst)) |=> wr_ready);

    // R9
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (wr_ready && !scan_valid));

endmodule

bind vram_arb_top vram_arb_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .scan_req   (scan_req),
    .scan_valid (scan_valid),
    .wr_valid   (wr_valid),
    .wr_ready   (wr_ready),
    .wr_nib     (wr_nib)
);

// File: tb/vram_arb_top_test.sv
module vram_arb_top_test;
    localparam int AW    = 8;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          scan_req = 1'b0;
    logic [AW-1:0] scan_addr = '0;
    logic          scan_valid;
    logic [31:0]   scan_data;
    logic          wr_valid = 1'b0;
    logic          wr_ready;
    logic          wr_nib = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [2:0]    wr_sub = '0;
    logic [31:0]   wr_data = '0;

    vram_arb_top #(.ADDR_W(AW)) uut (
        .clk(clk), .rst(rst),
        .scan_req(scan_req), .scan_addr(scan_addr),
        .scan_valid(scan_valid), .scan_data(scan_data),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_nib(wr_nib),
        .wr_addr(wr_addr), .wr_sub(wr_sub), .wr_data(wr_data)
    );

    always #10 clk = ~clk;

    typedef struct {
        logic [31:0] val;
        string       tag;
    } exp_t;

    logic [31:0] model [DEPTH];
    exp_t        expq [$];
    int          checks = 0;
    int          errors = 0;

    function automatic logic [31:0] ref_nib(input logic [31:0] w, input logic [2:0] s,
                                            input logic [3:0] n);
        logic [31:0] mask;
        mask = 32'hF << (4 * s);
        return (w & ~mask) | ((32'(n) << (4 * s)) & mask);
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst && scan_valid) begin
            if (expq.size() == 0) begin
                check(1'b0, "R2 unexpected scan_valid", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = expq.pop_front();
                check(scan_data === e.val, e.tag, scan_data, e.val);
            end
        end
    end

    task automatic wait_idle();
        @(negedge clk);
        while (!wr_ready) @(negedge clk);
    endtask

    task automatic wr_op(input bit nib, input logic [AW-1:0] a, input logic [2:0] s,
                         input logic [31:0] d, output int waits);
        @(negedge clk);
        wr_valid = 1'b1; wr_nib = nib; wr_addr = a; wr_sub = s; wr_data = d;
        waits = 0;
        while (!wr_ready) begin
            @(negedge clk);
            waits++;
        end
        @(posedge clk);
        #1 wr_valid = 1'b0;
        model[a] = nib ? ref_nib(model[a], s, d[3:0]) : d;
    endtask

    task automatic scan_rd(input logic [AW-1:0] a, input string tag);
        exp_t e;
        @(negedge clk);
        scan_req = 1'b1; scan_addr = a;
        e.val = model[a]; e.tag = tag;
        expq.push_back(e);
        @(posedge clk);
        #1 scan_req = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        check(1'b0, "watchdog expired", 32'd0, 32'd1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int w;
        exp_t e;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(wr_ready === 1'b1, "R9 wr_ready in reset", 32'(wr_ready), 32'd1);
        check(scan_valid === 1'b0, "R9 scan_valid in reset", 32'(scan_valid), 32'd0);
        rst = 1'b0;

        // R4: fill every word with back-to-back full writes
        for (int i = 0; i < DEPTH; i++) begin
            wr_op(1'b0, AW'(i), 3'd0, 32'h9E37_79B9 * (i + 1), w);
            if (i % 32 == 0) check(w == 0, "R4 full write stalled", 32'(w), 32'd0);
        end
        for (int i = 0; i < DEPTH; i++) scan_rd(AW'(i), "R4 full write readback");

        // R5: every nibble index of one word
        for (int s = 0; s < 8; s++) begin
            wait_idle();
            wr_op(1'b1, AW'(5), 3'(s), 32'hFFFF_FFF0 | 32'(s + 3), w);
            wait_idle();
            scan_rd(AW'(5), "R5 nibble merge");
        end

        // R6 / R8 / R3: scanout of same word across a nibble update
        wait_idle();
        @(negedge clk);
        wr_valid = 1'b1; wr_nib = 1'b1; wr_addr = AW'(7); wr_sub = 3'd6; wr_data = 32'hC;
        scan_req = 1'b1; scan_addr = AW'(7);
        e.val = model[7]; e.tag = "R8 read on accept edge"; expq.push_back(e);
        @(posedge clk);
        #1 wr_valid = 1'b0;
        @(negedge clk);
        check(wr_ready === 1'b0, "R6 ready low cycle 1", 32'(wr_ready), 32'd0);
        e.tag = "R8 read on fetch edge"; expq.push_back(e);
        @(negedge clk);
        check(wr_ready === 1'b0, "R6 ready low cycle 2", 32'(wr_ready), 32'd0);
        e.tag = "R3 R8 read on write-back edge"; expq.push_back(e);
        @(posedge clk);
        #1 scan_req = 1'b0;
        @(negedge clk);
        check(wr_ready === 1'b1, "R6 ready back", 32'(wr_ready), 32'd1);
        model[7] = ref_nib(model[7], 3'd6, 4'hC);
        scan_rd(AW'(7), "R6 write-back landed");

        // R8: full write and scanout of the same word in one cycle
        wait_idle();
        @(negedge clk);
        wr_valid = 1'b1; wr_nib = 1'b0; wr_addr = AW'(20); wr_data = 32'h1234_ABCD;
        scan_req = 1'b1; scan_addr = AW'(20);
        e.val = model[20]; e.tag = "R8 same-cycle collision"; expq.push_back(e);
        @(posedge clk);
        #1 begin wr_valid = 1'b0; scan_req = 1'b0; end
        model[20] = 32'h1234_ABCD;
        scan_rd(AW'(20), "R8 after collision");

        // R7: held writes, two nibbles of one byte, then a held full write
        wait_idle();
        wr_op(1'b1, AW'(9), 3'd2, 32'h5, w);
        wr_op(1'b1, AW'(9), 3'd3, 32'hA, w);
        check(w == 2, "R7 second nibble held", 32'(w), 32'd2);
        wr_op(1'b0, AW'(10), 3'd0, 32'hDEAD_0001, w);
        check(w == 2, "R7 full write held", 32'(w), 32'd2);
        wait_idle();
        scan_rd(AW'(9), "R7 both nibbles kept");
        scan_rd(AW'(10), "R7 held full write");

        // R10: random mix
        for (int k = 0; k < 400; k++) begin
            logic [AW-1:0] a;
            a = AW'($urandom_range(0, 15));
            wr_op(1'($urandom_range(0, 1)), a, 3'($urandom_range(0, 7)), $urandom, w);
            if (k % 4 == 0) begin
                wait_idle();
                scan_rd(AW'($urandom_range(0, 15)), "R10 mixed traffic");
            end
        end
        wait_idle();
        for (int i = 0; i < DEPTH; i++) scan_rd(AW'(i), "R10 final contents");

        // R2: idle, no strobes expected
        repeat (6) @(negedge clk);
        check(expq.size() == 0, "R1 all reads returned", 32'(expq.size()), 32'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule